// File: doc/BRIEF.md
# Half-Duplex Line Direction Arbiter

This block sits between a host-side serial data line and a card-side serial data line that share one half-duplex channel. Neither side tells it which way data flows. It watches the sampled level of both lines. The first line seen falling becomes the input. The block then pulls the opposite line low after a programmable fall delay, copying the input. When the input line rises, the block lets the copy go after a shorter programmable rise delay and returns to a neutral state in which it drives nothing.

Arbitration runs only while a session is active and the activation sequencer has turned reception on. Before reception is on, including straight after reset, the card line is held low and the host line is left alone. A separate monitor counts how long the host line stays low. If it stays low past a programmable character-time window, the monitor raises a sticky lock flag so the controller can tear the session down and start it again.

Top module: `hdx_line_arbiter`

## Requirements
- R1: While reset is asserted, `card_pull_o` is 1, `host_pull_o` is 0 and `stuck_o` is 0.
- R2: After any clock edge that samples `rx_en_i` low, `card_pull_o` is 1 and no host edge is forwarded. After the first edge that samples `rx_en_i` high with the channel idle, `card_pull_o` is 0.
- R3: A host-line falling edge sampled in neutral, with `sess_i` and `rx_en_i` both high, makes `card_pull_o` 1 exactly FALL_DLY clock edges after the edge that saw it. `host_pull_o` stays 0 throughout.
- R4: A card-line falling edge sampled in neutral makes `host_pull_o` 1 exactly FALL_DLY edges later. `card_pull_o` stays 0 throughout.
- R5: Once a line is being copied, a rising edge on the input line releases the copy (the pull goes to 0) exactly RISE_DLY edges after the edge that saw the rise. The block is then neutral again.
- R6: If both lines are first seen low on the same edge, the host line becomes the input, so only `card_pull_o` is asserted. The card pull is held until the host line rises, even if the card side lets go first.
- R7: While `sess_i` is low, edges on either line are ignored. One edge after `sess_i` is sampled low, both pulls are 0, provided `rx_en_i` is high.
- R8: `host_pull_o` and `card_pull_o` are never 1 in the same cycle.
- R9: An input low pulse that rises again before the fall delay has run out is not forwarded, and the block returns to neutral.
- R10: `stuck_o` goes to 1 on the LOCK_CYCLES-th consecutive edge that samples the host line low during a session. It then stays 1 while `sess_i` is high, and drops to 0 one edge after `sess_i` is sampled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_lvl_i | input | 1 | Sampled level of the host-side data line |
| card_lvl_i | input | 1 | Sampled level of the card-side data line |
| rx_en_i | input | 1 | Reception enable from the activation sequencer |
| sess_i | input | 1 | Session active |
| host_pull_o | output | 1 | Pull the host-side line low |
| card_pull_o | output | 1 | Pull the card-side line low |
| stuck_o | output | 1 | Sticky flag: host line held low too long |

## Verification
The assertions assume that both line inputs are synchronous samples that settle away from the active edge. They also assume that each line reads low whenever the block pulls it, so that a rise on a forwarded output can only come after the block has released it. The bench keeps to these assumptions in three ways. It models each line as a wired-AND of the external pull and the block's own pull. It changes stimulus only on the falling clock edge. It leaves an idle cycle after each release before starting a new transfer, so the edge detector sees a clean high-to-low step.

// File: rtl/hdx_arb_pkg.sv
package hdx_arb_pkg;

   typedef enum logic [1:0] {
      LS_NEUTRAL = 2'd0,
      LS_ARMED   = 2'd1,
      LS_FORWARD = 2'd2,
      LS_RELEASE = 2'd3
   } link_st_e;

   typedef enum logic {
      DIR_HOST_IN = 1'b0,
      DIR_CARD_IN = 1'b1
   } dir_e;

   localparam int unsigned HOST_IDX  = 0;
   localparam int unsigned CARD_IDX  = 1;
   localparam int unsigned NUM_LINES = 2;

endpackage

// File: rtl/hdx_edge_det.sv
module hdx_edge_det #(
   parameter int unsigned LINES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [LINES-1:0] lvl_i,
   output logic [LINES-1:0] fall_o,
   output logic [LINES-1:0] rise_o
);

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic prev_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) prev_q <= 1'b1;
         else         prev_q <= lvl_i[g];
      end

      assign fall_o[g] = prev_q & ~lvl_i[g];
      assign rise_o[g] = ~prev_q & lvl_i[g];
   end

endmodule

// File: rtl/hdx_dir_fsm.sv
module hdx_dir_fsm
   import hdx_arb_pkg::*;
#(
   parameter int unsigned FALL_DLY = 4,
   parameter int unsigned RISE_DLY = 1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 active_i,
   input  logic [NUM_LINES-1:0] fall_i,
   input  logic [NUM_LINES-1:0] rise_i,
   output logic                 fwd_to_card_o,
   output logic                 fwd_to_host_o
);

   localparam int unsigned CW = $clog2(FALL_DLY + 1);

   link_st_e        st_q;
   dir_e            dir_q;
   logic [CW-1:0]   cnt_q;
   logic            in_fall, in_rise, driving;

   assign in_fall = (dir_q == DIR_HOST_IN) ? fall_i[HOST_IDX] : fall_i[CARD_IDX];
   assign in_rise = (dir_q == DIR_HOST_IN) ? rise_i[HOST_IDX] : rise_i[CARD_IDX];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= LS_NEUTRAL;
         dir_q <= DIR_HOST_IN;
         cnt_q <= '0;
      end else if (!active_i) begin
         st_q  <= LS_NEUTRAL;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            LS_NEUTRAL: begin
               // host side checked first: it wins a same-cycle tie
               if (fall_i[HOST_IDX]) begin
                  dir_q <= DIR_HOST_IN;
                  st_q  <= LS_ARMED;
                  cnt_q <= CW'(FALL_DLY - 1);
               end else if (fall_i[CARD_IDX]) begin
                  dir_q <= DIR_CARD_IN;
                  st_q  <= LS_ARMED;
                  cnt_q <= CW'(FALL_DLY - 1);
               end
            end
            LS_ARMED: begin
               if (in_rise)           st_q  <= LS_NEUTRAL;
               else if (cnt_q == '0)  st_q  <= LS_FORWARD;
               else                   cnt_q <= cnt_q - 1'b1;
            end
            LS_FORWARD: begin
               if (in_rise) begin
                  st_q  <= LS_RELEASE;
                  cnt_q <= CW'(RISE_DLY - 1);
               end
            end
            LS_RELEASE: begin
               if (in_fall)           st_q  <= LS_FORWARD;
               else if (cnt_q == '0)  st_q  <= LS_NEUTRAL;
               else                   cnt_q <= cnt_q - 1'b1;
            end
            default: st_q <= LS_NEUTRAL;
         endcase
      end
   end

   assign driving       = (st_q == LS_FORWARD) || (st_q == LS_RELEASE);
   assign fwd_to_card_o = driving && (dir_q == DIR_HOST_IN);
   assign fwd_to_host_o = driving && (dir_q == DIR_CARD_IN);

endmodule

// File: rtl/hdx_lock_mon.sv
module hdx_lock_mon #(
   parameter int unsigned LOCK_CYCLES = 4096
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sess_i,
   input  logic host_lvl_i,
   output logic stuck_o
);

   localparam int unsigned CW = $clog2(LOCK_CYCLES + 1);

   logic [CW-1:0] cnt_q;
   logic          stuck_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         stuck_q <= 1'b0;
      end else if (!sess_i) begin
         cnt_q   <= '0;
         stuck_q <= 1'b0;
      end else if (host_lvl_i) begin
         cnt_q   <= '0;
      end else if (cnt_q == CW'(LOCK_CYCLES - 1)) begin
         stuck_q <= 1'b1;
      end else begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign stuck_o = stuck_q;

endmodule

// File: rtl/hdx_line_arbiter.sv
module hdx_line_arbiter
   import hdx_arb_pkg::*;
#(
   parameter int unsigned FALL_DLY    = 4,
   parameter int unsigned RISE_DLY    = 1,
   parameter int unsigned LOCK_CYCLES = 4096
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic host_lvl_i,
   input  logic card_lvl_i,
   input  logic rx_en_i,
   input  logic sess_i,
   output logic host_pull_o,
   output logic card_pull_o,
   output logic stuck_o
);

   if (RISE_DLY < 1 || FALL_DLY < RISE_DLY) begin : g_bad_dly
      $error("hdx_line_arbiter: need 1 <= RISE_DLY <= FALL_DLY");
   end
   if (LOCK_CYCLES < 2) begin : g_bad_lock
      $error("hdx_line_arbiter: LOCK_CYCLES must be at least 2");
   end

   logic [NUM_LINES-1:0] lvl, fall, rise;
   logic                 rx_on_q, active, to_card, to_host;

   assign lvl[HOST_IDX] = host_lvl_i;
   assign lvl[CARD_IDX] = card_lvl_i;
   assign active        = rx_en_i & sess_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rx_on_q <= 1'b0;
      else         rx_on_q <= rx_en_i;
   end

   hdx_edge_det #(.LINES(NUM_LINES)) edge_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (lvl),
      .fall_o (fall),
      .rise_o (rise)
   );

   hdx_dir_fsm #(.FALL_DLY(FALL_DLY), .RISE_DLY(RISE_DLY)) fsm_i (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .active_i      (active),
      .fall_i        (fall),
      .rise_i        (rise),
      .fwd_to_card_o (to_card),
      .fwd_to_host_o (to_host)
   );

   hdx_lock_mon #(.LOCK_CYCLES(LOCK_CYCLES)) lock_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sess_i     (sess_i),
      .host_lvl_i (host_lvl_i),
      .stuck_o    (stuck_o)
   );

   assign card_pull_o = ~rx_on_q | to_card;
   assign host_pull_o = to_host;

endmodule

// File: rtl/hdx_line_arbiter_chk.sv
module hdx_line_arbiter_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic host_lvl_i,
   input logic card_lvl_i,
   input logic rx_en_i,
   input logic sess_i,
   input logic host_pull_o,
   input logic card_pull_o,
   input logic stuck_o
);

   // R8
   excl_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(host_pull_o && card_pull_o));

   // R7
   sess_off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sess_i && rx_en_i) |=> (!host_pull_o && !card_pull_o));

   // R2
   rx_off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rx_en_i |=> (card_pull_o && !host_pull_o));

   // R10
   stuck_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stuck_o && sess_i) |=> stuck_o);

   // R10
   stuck_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sess_i |=> !stuck_o);

   // R4
   host_fwd_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(host_pull_o) |-> $past(!card_lvl_i));

   // R3
   card_fwd_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(card_pull_o) && $past(rx_en_i)) |-> $past(!host_lvl_i));

endmodule

bind hdx_line_arbiter hdx_line_arbiter_chk chk_i (.*);

// File: tb/hdx_line_arbiter_tb_top.sv
module hdx_line_arbiter_tb_top;

   localparam int unsigned LOCK_N = 24;
   localparam int NV = 47;

   // entry: {req code[3:0], sess, rx, host_ext_low, card_ext_low, exp_host_pull, exp_card_pull}
   localparam logic [9:0] VEC [NV] = '{
      {4'd2, 6'b110000},                                           // rx on, card released
      {4'd3, 6'b111000}, {4'd3, 6'b111000}, {4'd3, 6'b111000},
      {4'd3, 6'b111000}, {4'd3, 6'b111001}, {4'd3, 6'b111001},     // host fall forwarded after 4
      {4'd5, 6'b110001}, {4'd5, 6'b110000}, {4'd5, 6'b110000},     // host rise, release after 1
      {4'd4, 6'b110100}, {4'd4, 6'b110100}, {4'd4, 6'b110100},
      {4'd4, 6'b110100}, {4'd4, 6'b110110},                        // card fall forwarded
      {4'd5, 6'b110010}, {4'd5, 6'b110000}, {4'd5, 6'b110000},
      {4'd9, 6'b111000}, {4'd9, 6'b110000}, {4'd9, 6'b110000},     // short glitch dropped
      {4'd9, 6'b110000}, {4'd9, 6'b110000},
      {4'd6, 6'b111100}, {4'd6, 6'b111100}, {4'd6, 6'b111100},     // tie: host wins
      {4'd6, 6'b111100}, {4'd6, 6'b111101}, {4'd6, 6'b111001},
      {4'd6, 6'b110001}, {4'd6, 6'b110000},
      {4'd7, 6'b010100}, {4'd7, 6'b010100}, {4'd7, 6'b010100},     // no session: ignored
      {4'd7, 6'b010100}, {4'd7, 6'b010100}, {4'd7, 6'b110100},
      {4'd7, 6'b110000}, {4'd7, 6'b110000},
      {4'd2, 6'b100001}, {4'd2, 6'b101001}, {4'd2, 6'b101001},     // rx off: card held, host ignored
      {4'd2, 6'b101001}, {4'd2, 6'b101001}, {4'd2, 6'b101001},
      {4'd2, 6'b100001}, {4'd2, 6'b110000}
   };

   logic clk = 1'b0;
   logic rst_n, sess, rx, hp, cp;
   logic host_lvl, card_lvl, host_pull, card_pull, stuck;
   int   n_run = 0, n_fail = 0;
   bit   done = 1'b0;

   always #10 clk = ~clk;

   assign host_lvl = ~(hp | host_pull);
   assign card_lvl = ~(cp | card_pull);

   hdx_line_arbiter #(.FALL_DLY(4), .RISE_DLY(1), .LOCK_CYCLES(LOCK_N)) dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .host_lvl_i  (host_lvl),
      .card_lvl_i  (card_lvl),
      .rx_en_i     (rx),
      .sess_i      (sess),
      .host_pull_o (host_pull),
      .card_pull_o (card_pull),
      .stuck_o     (stuck)
   );

   function automatic string tag_of(logic [3:0] c);
      case (c)
         4'd2:    return "R2";
         4'd3:    return "R3";
         4'd4:    return "R4";
         4'd5:    return "R5";
         4'd6:    return "R6";
         4'd7:    return "R7";
         default: return "R9";
      endcase
   endfunction

   task automatic check(string tag, string what, logic act, logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
      end
   endtask

   initial begin
      rst_n = 1'b0; sess = 1'b0; rx = 1'b0; hp = 1'b0; cp = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "card_pull", card_pull, 1'b1);
      check("R1", "host_pull", host_pull, 1'b0);
      check("R1", "stuck", stuck, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R2", "card_pull before rx", card_pull, 1'b1);

      for (int i = 0; i < NV; i++) begin
         {sess, rx, hp, cp} = VEC[i][5:2];
         @(negedge clk);
         check(tag_of(VEC[i][9:6]), $sformatf("host_pull v%0d", i), host_pull, VEC[i][1]);
         check(tag_of(VEC[i][9:6]), $sformatf("card_pull v%0d", i), card_pull, VEC[i][0]);
         check("R8", $sformatf("both pulls v%0d", i), host_pull & card_pull, 1'b0);
      end

      // R10 lock window
      hp = 1'b1;
      repeat (LOCK_N - 1) @(negedge clk);
      check("R10", "stuck before window", stuck, 1'b0);
      @(negedge clk);
      check("R10", "stuck at window", stuck, 1'b1);
      hp = 1'b0;
      repeat (3) @(negedge clk);
      check("R10", "stuck sticky", stuck, 1'b1);
      sess = 1'b0;
      @(negedge clk);
      check("R10", "stuck cleared", stuck, 1'b0);
      check("R7", "host_pull off session", host_pull, 1'b0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(200_000 * 20);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule